// File: doc/BRIEF.md
# Ethernet frame FCS appender

This block sits in a transmit path and takes one Ethernet frame at a time as a byte stream. The stream runs from the first destination-address byte to the last payload byte. Every byte goes to the output unchanged, one output byte for each accepted input byte. At the same time the block keeps a CRC-32 over those bytes. When it accepts the byte marked as end of frame, it appends the four-byte Frame Check Sequence directly behind it. The end-of-frame marker on the output then moves to the last of those four bytes.

Both sides use a valid/ready byte handshake with start and end markers. The CRC register is preset to all ones when a start marker is accepted, which has the same effect as inverting the first 32 covered bits. The register is inverted again to form the sequence that is sent. While the four check bytes go out, the input side is held off. Output stalls never lose or repeat a byte.

Top module: `fcs_tail_appender`

## Requirements
- R1: After a synchronous reset, `out_valid` is 0 and `in_ready` is 1.
- R2: Each accepted input byte appears on the output once, in order, with the same value. Its `out_sof` equals the `in_sof` it was accepted with, and its `out_eof` is 0.
- R3: The CRC uses the polynomial 0x04C11DB7. Each byte is fed least-significant bit first. The register is preset to all ones on a byte accepted with `in_sof`=1. For the nine-byte frame "123456789" (0x31..0x39) the appended bytes are 0x26, 0x39, 0xF4, 0xCB, in that order.
- R4: The appended value is the complement of the CRC remainder over the frame. It is sent as four bytes directly after the last data byte. Coefficient x31 goes first on the line: byte 0 carries x31..x24 with x31 in bit 0, byte 1 carries x23..x16, and so on.
- R5: `out_eof` is 1 only on the fourth appended byte. A byte with `out_sof`=1 never has `out_eof`=1.
- R6: With the output never stalled, `in_ready` is 0 for exactly the four cycles after the end-of-frame byte is accepted, and is 1 again in the fifth cycle.
- R7: While `out_valid`=1 and `out_ready`=0, the output byte and its markers stay unchanged. Under any stall pattern no byte is dropped or duplicated.
- R8: The CRC advances only on accepted input bytes. Cycles with `in_valid`=0, or with `in_ready`=0, do not change the appended value.
- R9: Frames sent back to back with no idle cycle each get the same check value they would get if sent alone.
- R10: Running the same CRC (preset all ones, no final complement) over a frame followed by its four appended bytes gives the residue 0xC704DD7B.
- R11: For a 44-byte frame with broadcast destination FF:FF:FF:FF:FF:FF and type 0x0800 carrying a UDP datagram, the appended bytes match an independent reference computation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input byte is present |
| in_ready | output | 1 | Block takes the input byte this cycle |
| in_data | input | 8 | Input frame byte |
| in_sof | input | 1 | Input byte is the first of a frame |
| in_eof | input | 1 | Input byte is the last payload byte |
| out_valid | output | 1 | Output byte is present |
| out_ready | input | 1 | Downstream takes the output byte |
| out_data | output | 8 | Output byte, a data byte or a check byte |
| out_sof | output | 1 | Output byte is the first of a frame |
| out_eof | output | 1 | Output byte is the last check byte |

## Verification
The assertions check the cycle-level rules on every clock:
- each accepted byte shows up on the output in the next cycle with the same value and marker;
- a stalled output stays frozen;
- the input is held off right after an end-of-frame byte;
- the CRC register moves only on accepted bytes;
- a start byte is never also an end byte.

The value of the check bytes can only be shown by the bench's scenarios. These cover the nine-byte known vector, a broadcast UDP frame checked against a separate bit-serial reference, the residue over frame plus check bytes, a single-byte frame, random output stalls with input gaps, and back-to-back frames.

// File: rtl/fcs_pkg.sv
package fcs_pkg;

  // CRC-32 polynomial 0x04C11DB7, bit-reversed for an LSB-first shift register
  localparam logic [31:0] ETH_POLY_LSB_FIRST = 32'hEDB88320;
  localparam logic [31:0] ETH_CRC_PRESET     = 32'hFFFF_FFFF;

  typedef enum logic {
    ST_PASS,
    ST_TAIL
  } fcs_state_e;

endpackage

// File: rtl/fcs_crc_accum.sv
module fcs_crc_accum #(
  parameter int          DATA_W = 8,
  parameter int          CRC_W  = 32,
  parameter logic [31:0] POLY   = fcs_pkg::ETH_POLY_LSB_FIRST,
  parameter logic [31:0] PRESET = fcs_pkg::ETH_CRC_PRESET
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step,
  input  logic              restart,
  input  logic [DATA_W-1:0] din,
  output logic [CRC_W-1:0]  crc_q
);

  // one stage per input bit, LSB first
  logic [CRC_W-1:0] stage [0:DATA_W];

  assign stage[0] = (restart ? PRESET[CRC_W-1:0] : crc_q) ^ CRC_W'(din);

  generate
    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
      assign stage[b+1] = stage[b][0] ? ((stage[b] >> 1) ^ POLY[CRC_W-1:0])
                                      : (stage[b] >> 1);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)       crc_q <= PRESET[CRC_W-1:0];
    else if (step) crc_q <= stage[DATA_W];
  end

  // R8: register moves only on an accepted byte
  a_r8_crc_only_on_step: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(crc_q));

endmodule

// File: rtl/fcs_tail_ctrl.sv
module fcs_tail_ctrl #(
  parameter int FCS_BYTES = 4,
  parameter int IDX_W     = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             in_eof,
  input  logic             out_free,
  output logic             in_ready,
  output logic             accept,
  output logic             tail_load,
  output logic [IDX_W-1:0] tail_idx,
  output logic             tail_last
);
  import fcs_pkg::*;

  fcs_state_e       state_q;
  logic [IDX_W-1:0] idx_q;

  assign in_ready  = (state_q == ST_PASS) && out_free;
  assign accept    = in_valid && in_ready;
  assign tail_load = (state_q == ST_TAIL) && out_free;
  assign tail_idx  = idx_q;
  assign tail_last = (idx_q == IDX_W'(FCS_BYTES - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_PASS;
      idx_q   <= '0;
    end else begin
      case (state_q)
        ST_PASS: begin
          if (accept && in_eof) begin
            state_q <= ST_TAIL;
            idx_q   <= '0;
          end
        end
        ST_TAIL: begin
          if (tail_load) begin
            idx_q <= idx_q + 1'b1;
            if (tail_last) state_q <= ST_PASS;
          end
        end
        default: state_q <= ST_PASS;
      endcase
    end
  end

  // R6: input is held off in the cycle after an end-of-frame byte is taken
  a_r6_block_after_eof: assert property (@(posedge clk) disable iff (rst)
    (accept && in_eof) |=> !in_ready);

  // R6: no input is taken while check bytes are pending
  a_r6_no_accept_in_tail: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_TAIL) |-> !accept);

endmodule

// File: rtl/fcs_out_reg.sv
module fcs_out_reg #(
  parameter int DATA_W = 8,
  parameter int CRC_W  = 32,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pass_load,
  input  logic [DATA_W-1:0] pass_data,
  input  logic              pass_sof,
  input  logic              tail_load,
  input  logic [CRC_W-1:0]  fcs_value,
  input  logic [IDX_W-1:0]  tail_idx,
  input  logic              tail_last,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_sof,
  output logic              out_eof
);

  logic [CRC_W-1:0]  fcs_shifted;
  logic [DATA_W-1:0] tail_byte;

  // byte 0 holds the low bits of the LSB-first register, i.e. x31 in bit 0
  assign fcs_shifted = fcs_value >> (int'(tail_idx) * DATA_W);
  assign tail_byte   = fcs_shifted[DATA_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_sof   <= 1'b0;
      out_eof   <= 1'b0;
    end else if (pass_load) begin
      out_valid <= 1'b1;
      out_data  <= pass_data;
      out_sof   <= pass_sof;
      out_eof   <= 1'b0;
    end else if (tail_load) begin
      out_valid <= 1'b1;
      out_data  <= tail_byte;
      out_sof   <= 1'b0;
      out_eof   <= tail_last;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R7: stalled output stays frozen
  a_r7_hold_on_stall: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) &&
                                   $stable(out_sof) && $stable(out_eof)));

  // R5: a start byte is never the end byte
  a_r5_sof_not_eof: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_sof) |-> !out_eof);

endmodule

// File: rtl/fcs_tail_appender.sv
module fcs_tail_appender #(
  parameter int DATA_W = 8,
  parameter int CRC_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_sof,
  input  logic              in_eof,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_sof,
  output logic              out_eof
);

  localparam int FCS_BYTES = CRC_W / DATA_W;
  localparam int IDX_W     = (FCS_BYTES > 1) ? $clog2(FCS_BYTES) : 1;

  logic             out_free;
  logic             accept;
  logic             tail_load;
  logic [IDX_W-1:0] tail_idx;
  logic             tail_last;
  logic [CRC_W-1:0] crc_q;
  logic [CRC_W-1:0] fcs_value;

  assign out_free  = !out_valid || out_ready;
  assign fcs_value = ~crc_q;

  fcs_crc_accum #(
    .DATA_W (DATA_W),
    .CRC_W  (CRC_W)
  ) u_crc (
    .clk     (clk),
    .rst     (rst),
    .step    (accept),
    .restart (in_sof),
    .din     (in_data),
    .crc_q   (crc_q)
  );

  fcs_tail_ctrl #(
    .FCS_BYTES (FCS_BYTES),
    .IDX_W     (IDX_W)
  ) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_eof    (in_eof),
    .out_free  (out_free),
    .in_ready  (in_ready),
    .accept    (accept),
    .tail_load (tail_load),
    .tail_idx  (tail_idx),
    .tail_last (tail_last)
  );

  fcs_out_reg #(
    .DATA_W (DATA_W),
    .CRC_W  (CRC_W),
    .IDX_W  (IDX_W)
  ) u_out (
    .clk       (clk),
    .rst       (rst),
    .pass_load (accept),
    .pass_data (in_data),
    .pass_sof  (in_sof),
    .tail_load (tail_load),
    .fcs_value (fcs_value),
    .tail_idx  (tail_idx),
    .tail_last (tail_last),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_sof   (out_sof),
    .out_eof   (out_eof)
  );

  // R2: an accepted byte is on the output one cycle later, unchanged
  a_r2_pass_through: assert property (@(posedge clk) disable iff (rst)
    accept |=> (out_valid && out_data == $past(in_data) &&
                out_sof == $past(in_sof) && !out_eof));

  // R1: reset leaves the output empty and the input open
  a_r1_reset_state: assert property (@(posedge clk)
    $past(rst) |-> (!out_valid && in_ready));

endmodule

// File: tb/fcs_tail_appender_test.sv
module fcs_tail_appender_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_data = 8'h00;
  logic       in_sof = 1'b0;
  logic       in_eof = 1'b0;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic [7:0] out_data;
  logic       out_sof;
  logic       out_eof;

  always #10 clk = ~clk;

  fcs_tail_appender uut (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_sof(in_sof), .in_eof(in_eof),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_sof(out_sof), .out_eof(out_eof)
  );

  int n_checks = 0;
  int n_fail   = 0;

  logic [7:0] tx      [0:255];
  logic [7:0] rx_d    [0:511];
  logic       rx_s    [0:511];
  logic       rx_e    [0:511];
  logic [7:0] scratch [0:511];
  int         rx_cnt = 0;
  logic       stall_on = 1'b0;
  logic [7:0] lfsr = 8'h5A;

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // independent reference: MSB-first shift register with the plain polynomial
  function automatic logic [31:0] model_crc(input int n);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int i = 0; i < n; i++) begin
      for (int b = 0; b < 8; b++) begin
        logic fb = c[31] ^ scratch[i][b];
        c = {c[30:0], 1'b0};
        if (fb) c = c ^ 32'h04C11DB7;
      end
    end
    return c;
  endfunction

  function automatic logic [7:0] rev8(input logic [7:0] v);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = v[7-i];
    return r;
  endfunction

  // byte k on the line: x(31-8k) first, carried in bit 0
  function automatic logic [7:0] fcs_byte(input logic [31:0] rem, input int k);
    logic [31:0] f = ~rem;
    return rev8(f[31-8*k -: 8]);
  endfunction

  // output monitor
  initial begin
    forever begin
      @(posedge clk);
      if (out_valid && out_ready) begin
        rx_d[rx_cnt] = out_data;
        rx_s[rx_cnt] = out_sof;
        rx_e[rx_cnt] = out_eof;
        rx_cnt++;
      end
    end
  end

  // downstream ready, optionally stalled pseudo-randomly
  initial begin
    forever begin
      @(negedge clk);
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      out_ready = !stall_on || lfsr[0];
    end
  end

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  task automatic send_frame(input int len, input int gap, input bit hold);
    for (int i = 0; i < len; i++) begin
      if (gap > 0 && i > 0 && (i % gap) == 0) begin
        @(negedge clk);
        in_valid = 1'b0;
      end
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = tx[i];
      in_sof   = (i == 0);
      in_eof   = (i == len - 1);
      forever begin
        #9;
        if (in_ready) begin
          @(posedge clk);
          break;
        end
        @(negedge clk);
      end
    end
    if (!hold) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_sof   = 1'b0;
      in_eof   = 1'b0;
    end
  endtask

  task automatic collect(input int n, input string tag);
    int guard = 0;
    while (rx_cnt < n && guard < 5000) begin
      @(posedge clk);
      guard++;
    end
    repeat (6) @(posedge clk);
    check(rx_cnt == n, tag, rx_cnt, n);
  endtask

  task automatic check_frame(input int base, input int len, input string tag);
    int          mism = 0;
    int          sof_bad = 0;
    int          eof_bad = 0;
    logic [31:0] rem;
    logic [31:0] act_f;
    logic [31:0] exp_f;
    for (int i = 0; i < len; i++) begin
      if (rx_d[base+i] !== tx[i]) mism++;
      scratch[i] = tx[i];
    end
    check(mism == 0, {tag, " R2 data bytes"}, mism, 0);
    for (int i = 0; i < len + 4; i++) begin
      if (rx_s[base+i] !== (i == 0)) sof_bad++;
      if (rx_e[base+i] !== (i == len + 3)) eof_bad++;
    end
    check(sof_bad == 0, {tag, " R2 start marker"}, sof_bad, 0);
    check(eof_bad == 0, {tag, " R5 end marker on last check byte"}, eof_bad, 0);
    rem = model_crc(len);
    for (int k = 0; k < 4; k++) begin
      act_f[31-8*k -: 8] = rx_d[base+len+k];
      exp_f[31-8*k -: 8] = fcs_byte(rem, k);
    end
    check(act_f === exp_f, {tag, " R4 appended bytes"}, act_f, exp_f);
    for (int i = 0; i < len + 4; i++) scratch[i] = rx_d[base+i];
    rem = model_crc(len + 4);
    check(rem == 32'hC704DD7B, {tag, " R10 residue"}, rem, 32'hC704DD7B);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #9;
    check(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);
    check(in_ready == 1'b1, "R1 in_ready after reset", in_ready, 1);
  endtask

  task automatic t_known_vector;
    logic [31:0] act;
    for (int i = 0; i < 9; i++) tx[i] = 8'h31 + 8'(i);
    rx_cnt = 0;
    send_frame(9, 0, 1'b0);
    collect(13, "R3 byte count");
    act = {rx_d[9], rx_d[10], rx_d[11], rx_d[12]};
    check(act == 32'h2639F4CB, "R3 known vector", act, 32'h2639F4CB);
    check_frame(0, 9, "known");
  endtask

  task automatic t_broadcast_udp;
    logic [8*44-1:0] pkt;
    pkt = {48'hFFFFFFFFFFFF, 48'h020000AB0001, 16'h0800,
           160'h4500001E1C46000040110000C0A80001C0A800FF,
           64'h1F901F90000A0000, 16'h4242};
    for (int i = 0; i < 44; i++) tx[i] = pkt[8*(43-i) +: 8];
    rx_cnt = 0;
    send_frame(44, 0, 1'b0);
    collect(48, "R11 byte count");
    check_frame(0, 44, "R11 broadcast");
  endtask

  task automatic t_single_byte;
    tx[0] = 8'hA5;
    rx_cnt = 0;
    send_frame(1, 0, 1'b0);
    collect(5, "R4 single byte count");
    check_frame(0, 1, "R5 single byte");
  endtask

  task automatic t_ready_gap;
    int lows = 0;
    for (int i = 0; i < 8; i++) tx[i] = 8'hF0 - 8'(i);
    rx_cnt = 0;
    send_frame(8, 0, 1'b0);
    for (int k = 0; k < 4; k++) begin
      #9;
      if (!in_ready) lows++;
      @(negedge clk);
    end
    check(lows == 4, "R6 in_ready low during check bytes", lows, 4);
    #9;
    check(in_ready == 1'b1, "R6 in_ready back after check bytes", in_ready, 1);
    collect(12, "R6 byte count");
    check_frame(0, 8, "R6");
  endtask

  task automatic t_stall_gaps;
    for (int i = 0; i < 60; i++) tx[i] = 8'(i * 7 + 3);
    rx_cnt = 0;
    stall_on = 1'b1;
    send_frame(60, 5, 1'b0);
    collect(64, "R7 byte count under stall");
    stall_on = 1'b0;
    check_frame(0, 60, "R7 R8 stall");
  endtask

  task automatic t_back_to_back;
    for (int i = 0; i < 20; i++) tx[i] = 8'(8'h3C ^ 8'(i * 13));
    rx_cnt = 0;
    stall_on = 1'b1;
    send_frame(20, 0, 1'b1);
    send_frame(20, 0, 1'b0);
    collect(48, "R9 byte count");
    stall_on = 1'b0;
    check_frame(0, 20, "R9 first");
    check_frame(24, 20, "R9 second");
  endtask

  initial begin
    t_reset();
    t_known_vector();
    t_broadcast_udp();
    t_single_byte();
    t_ready_gap();
    t_stall_gaps();
    t_back_to_back();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule